// File: doc/BRIEF.md
# Bus-Hold DMA Request Sequencer

This block is the front end of a single-channel DMA engine that moves one word at a time between a peripheral and memory over a bus it borrows from a CPU. Software loads a start address, a word count, a transfer direction and an address step sign through a small load port. Each time the peripheral has a word ready it raises its request. The sequencer then asks the CPU for the bus with a hold request. Once the CPU grants the bus with its hold acknowledge, the sequencer acknowledges the peripheral and pulses one pair of read and write strobes for a single cycle. During that pulse it presents the current memory address.

After every word the address moves up or down by one and the count drops by one. The sequencer then gives the bus back and waits until the CPU has withdrawn its acknowledge before it accepts another request. This keeps the CPU from being locked out for the length of a whole block. When the word that empties the count completes, a sticky interrupt flag is raised. It stays set until software clears it.

Top module: `dma_hold_seq`

## Requirements
- R1: After reset, `hold`, `dack`, all four strobes and `irq` are low, and the word count is zero, so a request is ignored until a block is loaded.
- R2: With a nonzero count loaded and the sequencer idle, a `dreq` sampled high at one rising edge makes `hold` go high after the following rising edge, not earlier.
- R3: `dack` is asserted only while `hold` and `hlda` are both high. It starts the cycle after `hlda` is first sampled high, lasts exactly one cycle per word, and never occurs while `hlda` is withheld.
- R4: While `dack` is high, exactly one strobe pair is active. With `cfg_to_periph`=0 (peripheral to memory) it is `io_rd` and `mem_wr`; with `cfg_to_periph`=1 (memory to peripheral) it is `mem_rd` and `io_wr`. `mem_addr` shows the current word address.
- R5: After each word the address steps by +1 when `cfg_step_down`=0 and by -1 when it is 1, wrapping modulo 2^AW.
- R6: One request yields exactly one word. The internal request flag is cleared by `dack`, so a `dreq` held high moves the remaining words one at a time, each with its own hold/acknowledge exchange.
- R7: `hold` drops in the cycle after `dack`. It does not rise again while `hlda` is still high, however long `hlda` stays high.
- R8: The count decrements once per word. The word that brings it to zero raises `irq`, and with a zero count a `dreq` produces no `hold`.
- R9: `irq` stays high until `irq_clr` is sampled high. When completion and `irq_clr` coincide, completion wins and `irq` is high.
- R10: `cfg_load` is honoured only while the sequencer is idle. A load while the bus is requested or held changes neither the address nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for address, count, direction and step sign |
| cfg_addr | input | AW | Start memory address |
| cfg_count | input | CW | Number of words in the block |
| cfg_to_periph | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| cfg_step_down | input | 1 | 0: address increments, 1: address decrements |
| irq_clr | input | 1 | Clears the completion interrupt |
| dreq | input | 1 | Peripheral word-ready request |
| dack | output | 1 | Acknowledge to the peripheral, one cycle per word |
| hold | output | 1 | Bus request to the CPU |
| hlda | input | 1 | Bus grant from the CPU |
| mem_addr | output | AW | Current memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| irq | output | 1 | Sticky block-complete interrupt |

## Verification
The bench withholds the grant to catch a design that acknowledges the peripheral or strobes the bus before owning it. It also keeps the grant asserted after the bus is released, which exposes a design that re-requests before the CPU has let go and would deadlock or double-book the bus. A request held high across a whole block shows whether the request flag is really cleared by each acknowledge; a wrong flag produces burst words or skipped words. Wrap-around in the downward direction, a load attempted while the bus is requested, and a clear coinciding with completion cover a wrong counter width, a corrupted address, and a lost interrupt.

// File: rtl/dma_hold_seq.sv
module dma_hold_seq #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_to_periph,
  input  logic          cfg_step_down,
  input  logic          irq_clr,
  input  logic          dreq,
  output logic          dack,
  output logic          hold,
  input  logic          hlda,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          io_rd,
  output logic          io_wr,
  output logic          irq
);

  typedef enum logic [1:0] {S_IDLE, S_ASK, S_MOVE, S_GIVE} st_t;

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          to_periph_q;
  logic          down_q;
  logic          req_q;
  logic          irq_q;

  wire idle     = (st == S_IDLE);
  wire armed    = (cnt_q != '0);
  wire last     = (cnt_q == CNT_ONE);
  wire finish   = (st == S_MOVE) && last;

  assign hold     = (st == S_ASK) || (st == S_MOVE);
  assign dack     = (st == S_MOVE);
  assign mem_addr = addr_q;
  assign mem_wr   = dack && !to_periph_q;
  assign io_rd    = dack && !to_periph_q;
  assign mem_rd   = dack &&  to_periph_q;
  assign io_wr    = dack &&  to_periph_q;
  assign irq      = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (dack) begin
      req_q <= 1'b0;
    end else if (idle && dreq && armed) begin
      req_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      unique case (st)
        S_IDLE:  if (req_q && armed) st <= S_ASK;
        S_ASK:   if (hlda)           st <= S_MOVE;
        S_MOVE:                      st <= S_GIVE;
        S_GIVE:  if (!hlda)          st <= S_IDLE;
        default:                     st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      cnt_q       <= '0;
      to_periph_q <= 1'b0;
      down_q      <= 1'b0;
    end else if (idle && cfg_load) begin
      addr_q      <= cfg_addr;
      cnt_q       <= cfg_count;
      to_periph_q <= cfg_to_periph;
      down_q      <= cfg_step_down;
    end else if (dack) begin
      addr_q <= down_q ? addr_q - 1'b1 : addr_q + 1'b1;
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (finish)  irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

endmodule

// File: rtl/dma_hold_seq_chk.sv
module dma_hold_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dack,
  input logic          hold,
  input logic          hlda,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          io_rd,
  input logic          io_wr,
  input logic          irq,
  input logic          irq_clr,
  input logic          down_q
);

  AST_DACK_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (hold && hlda)) else $error("dack without bus"); // R3

  AST_DACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dack |=> !dack) else $error("dack longer than one cycle"); // R3

  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || io_rd || io_wr) |->
      (dack && ((mem_wr && io_rd && !mem_rd && !io_wr) ||
                (mem_rd && io_wr && !mem_wr && !io_rd))))
    else $error("bad strobe pair"); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dack |=> (mem_addr == (down_q ? $past(mem_addr) - 1'b1 : $past(mem_addr) + 1'b1)))
    else $error("address step wrong"); // R5

  AST_HOLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    dack |=> !hold) else $error("hold kept after word"); // R7

  AST_NO_EARLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> !hlda) else $error("hold raised while grant still high"); // R7

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq) else $error("irq lost"); // R9

endmodule

bind dma_hold_seq dma_hold_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dack(dack), .hold(hold), .hlda(hlda),
  .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_rd(io_rd), .io_wr(io_wr), .irq(irq), .irq_clr(irq_clr),
  .down_q(down_q)
);

// File: tb/dma_hold_seq_bench.sv
module dma_hold_seq_bench;
  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic          cfg_to_periph = 1'b0;
  logic          cfg_step_down = 1'b0;
  logic          irq_clr = 1'b0;
  logic          dreq = 1'b0;
  logic          dack, hold, hlda, mem_rd, mem_wr, io_rd, io_wr, irq;
  logic [AW-1:0] mem_addr;

  logic grant_en = 1'b1;
  logic sticky = 1'b0;
  logic hold_d;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_hold_seq #(.AW(AW), .CW(CW)) u_dma_hold_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
    .cfg_count(cfg_count), .cfg_to_periph(cfg_to_periph),
    .cfg_step_down(cfg_step_down), .irq_clr(irq_clr), .dreq(dreq),
    .dack(dack), .hold(hold), .hlda(hlda), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .irq(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_d <= 1'b0;
      hlda   <= 1'b0;
    end else begin
      hold_d <= hold;
      hlda   <= sticky ? hlda : (grant_en && hold_d);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  task automatic load(input logic [AW-1:0] a, input logic [CW-1:0] c,
                      input logic to_p, input logic dn);
    @(negedge clk);
    cfg_addr = a; cfg_count = c; cfg_to_periph = to_p; cfg_step_down = dn;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_dack(output bit seen);
    seen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk);
      if (dack) seen = 1;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!hold && !hlda) break;
    end
    @(negedge clk);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic word(input string tag, input logic [AW-1:0] exp_addr, input logic to_p);
    bit seen;
    dreq = 1'b1;
    wait_dack(seen);
    chk({tag, " R3 dack seen"}, seen, 1);
    chk({tag, " R3 bus owned"}, {hold, hlda}, 2'b11);
    chk({tag, " R4 address"}, mem_addr, exp_addr);
    chk({tag, " R4 strobes"}, {mem_rd, mem_wr, io_rd, io_wr}, to_p ? 4'b1001 : 4'b0110);
    dreq = 1'b0;
    @(negedge clk);
    chk({tag, " R3 dack one cycle"}, dack, 0);
    chk({tag, " R7 hold dropped"}, hold, 0);
    wait_idle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 outputs at reset", {hold, dack, mem_rd, mem_wr, io_rd, io_wr, irq}, 7'b0);
    rst_n = 1'b1;
    dreq = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1 no hold with empty count", hold, 0);
    dreq = 1'b0;
  endtask

  task automatic t_latency_dir();
    load(16'h0100, 2, 1'b0, 1'b0);
    dreq = 1'b1;
    @(negedge clk);
    chk("R2 hold not yet", hold, 0);
    @(negedge clk);
    chk("R2 hold after second edge", hold, 1);
    dreq = 1'b0;
    word("R4 p2m first", 16'h0100, 1'b0);
    word("R5 p2m up", 16'h0101, 1'b0);
    chk("R8 irq after last", irq, 1);
    clear_irq();
    chk("R9 irq cleared", irq, 0);
    load(16'h0040, 1, 1'b1, 1'b0);
    word("R4 m2p", 16'h0040, 1'b1);
    clear_irq();
  endtask

  task automatic t_grant_wait();
    bit seen;
    grant_en = 1'b0;
    load(16'h0500, 1, 1'b0, 1'b0);
    dreq = 1'b1;
    repeat (12) @(negedge clk);
    chk("R3 waiting hold", hold, 1);
    chk("R3 no dack without grant", dack, 0);
    load(16'h7777, 9, 1'b1, 1'b1);
    grant_en = 1'b1;
    wait_dack(seen);
    chk("R3 dack after grant", seen, 1);
    chk("R10 busy load ignored addr", mem_addr, 16'h0500);
    chk("R10 busy load ignored dir", {mem_rd, mem_wr, io_rd, io_wr}, 4'b0110);
    dreq = 1'b0;
    wait_idle();
    chk("R10 busy load ignored count", irq, 1);
    clear_irq();
  endtask

  task automatic t_wrap_down();
    load(16'h0001, 3, 1'b1, 1'b1);
    word("R5 down a", 16'h0001, 1'b1);
    word("R5 down b", 16'h0000, 1'b1);
    chk("R8 no irq mid block", irq, 0);
    word("R5 down wrap", 16'hFFFF, 1'b1);
    chk("R8 irq at end", irq, 1);
    clear_irq();
  endtask

  task automatic t_held_request();
    int n_dack = 0;
    int n_fall = 0;
    logic [AW-1:0] exp_a = 16'h0A00;
    logic prev_hold = 1'b0;
    load(16'h0A00, 3, 1'b0, 1'b0);
    dreq = 1'b1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (dack) begin
        chk("R6 word address", mem_addr, exp_a);
        exp_a = exp_a + 1'b1;
        n_dack++;
      end
      if (prev_hold && !hold) n_fall++;
      prev_hold = hold;
    end
    dreq = 1'b0;
    chk("R6 words per block", n_dack, 3);
    chk("R6 bus released per word", n_fall, 3);
    chk("R8 irq after held block", irq, 1);
    repeat (10) @(negedge clk);
    chk("R9 irq sticky", irq, 1);
    wait_idle();
    clear_irq();
  endtask

  task automatic t_sticky_grant();
    bit seen;
    int bad = 0;
    load(16'h0200, 2, 1'b0, 1'b0);
    dreq = 1'b1;
    wait_dack(seen);
    chk("R7 first word", seen, 1);
    sticky = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (hold) bad++;
    end
    chk("R7 no hold while grant high", bad, 0);
    sticky = 1'b0;
    wait_dack(seen);
    chk("R7 resumes after grant falls", seen, 1);
    chk("R5 second address", mem_addr, 16'h0201);
    dreq = 1'b0;
    wait_idle();
    clear_irq();
  endtask

  task automatic t_clear_race();
    bit seen;
    load(16'h0300, 1, 1'b0, 1'b0);
    irq_clr = 1'b1;
    dreq = 1'b1;
    wait_dack(seen);
    dreq = 1'b0;
    @(negedge clk);
    chk("R9 set wins over clear", irq, 1);
    @(negedge clk);
    chk("R9 clear next cycle", irq, 0);
    irq_clr = 1'b0;
    wait_idle();
    dreq = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 zero count ignores dreq", hold, 0);
    dreq = 1'b0;
  endtask

  initial begin
    t_reset();
    t_latency_dir();
    t_grant_wait();
    t_wrap_down();
    t_held_request();
    t_sticky_grant();
    t_clear_race();
    done = 1;
    finish_run();
  end

endmodule